// File: doc/BRIEF.md
# Multiplexed Display Row Scan Timing Generator

This block paces the row scan of a 65-row multiplexed liquid crystal panel. Every line period it advances a row counter through 64 ordinary rows followed by one dedicated indicator row. For each row it gives the display memory line to fetch and the common output to energise. The memory line is offset by a programmable first line, so software can scroll. The indicator row is never scrolled.

It also produces the polarity-alternation signal (FR) and a frame marker (SYNC). FR flips once per frame, or additionally every n lines when line-alternation mode is on. SYNC is a square wave of about half duty that rises with each frame. It also maps a pixel bit and the current polarity onto 2-bit drive level codes for the segment and common outputs.

In master mode the block drives FR, SYNC and the blanking line DOF. It drives the line clock only when its internal divider is chosen as the line-clock source. In slave mode it takes FR, SYNC, DOF and the line clock from a master chip, and uses the incoming SYNC to line up its row counter.

Top module: `lcdscan_timing`

## Requirements
- R1: The row index (`row_o`) starts at 0 after reset and steps by one on each line tick. After row 64 it returns to 0. Row 64 is the indicator row, flagged by `ind_row_o`=1. Between ticks the row index holds.
- R2: For rows 0..63, `ram_line_o` = (first line + row) mod 64. For the indicator row, `ram_line_o` is 0 whatever the first line is.
- R3: `com_idx_o` equals the row for normal direction (`cfg_com_rev_i`=0) and 63 minus the row for reversed direction. It is 0 on the indicator row.
- R4: The first line, the line-alternation count, its enable and the scan direction are taken from the inputs only on the tick that wraps row 64 to row 0. They reset to 0.
- R5: FR resets to 0 and toggles on every wrap tick. With line alternation off (`cfg_nen_i`=0), it changes on no other tick.
- R6: With line alternation on and count value v (`cfg_nval_i`), FR also toggles on each ordinary (non-wrap) tick that ends a run of v+1 ticks since the last toggle. A wrap restarts that run.
- R7: In master mode `sync_o` is 1 while the row is 0..32 and 0 while it is 33..64.
- R8: `fr_oe_o`, `sync_oe_o` and `dof_oe_o` equal `master_i`. `cl_oe_o` is 1 only when `master_i` and `int_osc_i` are both 1.
- R9: With the internal divider selected, a line tick occurs every CL_DIV clock cycles. `cl_o` is 1 during the first CL_DIV/2 cycles of each line period and 0 for the rest.
- R10: In slave mode `fr_o`, `sync_o` and `dof_o` follow `fr_i`, `sync_i` and `dof_i`. A tick that sees `sync_i`=1 after a tick that saw 0 sets the row to 1, since the master reached row 0 one line earlier.
- R11: Segment code (0=VDD, 1=V2, 2=V3, 3=V5). Let e = pixel XOR `cfg_disp_rev_i`. Then e=1 with FR=1 gives 0, e=1 with FR=0 gives 3, e=0 with FR=1 gives 1, and e=0 with FR=0 gives 2.
- R12: Common code (0=VDD, 1=V1, 2=V4, 3=V5). The selected row gets 3 when FR=1 and 0 when FR=0. Unselected rows get 1 when FR=1 and 2 when FR=0.
- R13: When `cfg_psave_i`=1, the segment code and both common codes are 0 (VDD).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1 = master, 0 = slave |
| int_osc_i | input | 1 | 1 = line clock from internal divider (master only) |
| cl_i | input | 1 | External line clock; a rising edge is a line tick |
| fr_i | input | 1 | Polarity from master (slave mode) |
| sync_i | input | 1 | Frame marker from master (slave mode) |
| dof_i | input | 1 | Blanking line from master (slave mode) |
| cfg_start_i | input | 6 | First display line for scrolling |
| cfg_nval_i | input | 6 | Line-alternation count, n-1 |
| cfg_nen_i | input | 1 | Line-alternation enable |
| cfg_com_rev_i | input | 1 | Reverse common scan direction |
| cfg_disp_rev_i | input | 1 | Invert pixel sense |
| cfg_psave_i | input | 1 | Power save: all codes VDD |
| cfg_disp_on_i | input | 1 | Display-on level driven on DOF in master mode |
| pix_i | input | 1 | Pixel bit to map |
| cl_o | output | 1 | Line clock out (generated or passed through) |
| cl_oe_o | output | 1 | Line clock output enable |
| fr_o | output | 1 | Effective polarity |
| fr_oe_o | output | 1 | FR output enable |
| sync_o | output | 1 | Effective frame marker |
| sync_oe_o | output | 1 | SYNC output enable |
| dof_o | output | 1 | Effective blanking line |
| dof_oe_o | output | 1 | DOF output enable |
| row_o | output | 7 | Current row, 0..64 |
| ind_row_o | output | 1 | Indicator row active |
| ram_line_o | output | 6 | Display memory line to read |
| com_idx_o | output | 6 | Common output being scanned |
| seg_lvl_o | output | 2 | Segment level code |
| com_act_lvl_o | output | 2 | Level code for the selected common |
| com_idle_lvl_o | output | 2 | Level code for unselected commons |

## Verification
A row counter off by one shows up at once as a wrong `ram_line_o` and `com_idx_o`, and as SYNC switching at the wrong row within one line period. A wrong FR phase or line-alternation count shows in the very next toggle, at most v+1 ticks later. A config register that loads mid-frame shows as an address or direction change before row 64 wraps. The bench follows the counters tick by tick against a model built from the requirements. It walks a table of pixel, polarity and inversion vectors for the level codes.

// File: rtl/lcdscan_pkg.sv
package lcdscan_pkg;
    // segment drive level codes
    localparam logic [1:0] SEG_VDD = 2'd0;
    localparam logic [1:0] SEG_V2  = 2'd1;
    localparam logic [1:0] SEG_V3  = 2'd2;
    localparam logic [1:0] SEG_V5  = 2'd3;
    // common drive level codes
    localparam logic [1:0] COM_VDD = 2'd0;
    localparam logic [1:0] COM_V1  = 2'd1;
    localparam logic [1:0] COM_V4  = 2'd2;
    localparam logic [1:0] COM_V5  = 2'd3;
endpackage

// File: rtl/lcdscan_tick.sv
module lcdscan_tick #(
    parameter int CL_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_osc,
    input  logic cl_i,
    output logic tick,
    output logic cl_gen
);
    localparam int DIV_W = (CL_DIV > 2) ? $clog2(CL_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CL_DIV - 1);
    localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(CL_DIV / 2);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             cl_prev;
    } tick_st_t;

    tick_st_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.cl_prev = cl_i;
        if (!use_osc) begin
            s_d.div = '0;
        end else if (s_q.div == DIV_LAST) begin
            s_d.div = '0;
        end else begin
            s_d.div = s_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick   = use_osc ? (s_q.div == DIV_LAST) : (cl_i & ~s_q.cl_prev);
    assign cl_gen = use_osc & (s_q.div < DIV_HALF);
endmodule

// File: rtl/lcdscan_seq.sv
module lcdscan_seq #(
    parameter int ROWS = 64,
    parameter int NW   = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic                          master,
    input  logic                          sync_i,
    input  logic [$clog2(ROWS)-1:0]       cfg_start,
    input  logic [NW-1:0]                 cfg_nval,
    input  logic                          cfg_nen,
    input  logic                          cfg_rev,
    output logic [$clog2(ROWS+1)-1:0]     row,
    output logic                          fr,
    output logic                          sync_gen,
    output logic [$clog2(ROWS)-1:0]       start_sh,
    output logic                          rev_sh
);
    localparam int LW      = $clog2(ROWS);
    localparam int RW      = $clog2(ROWS + 1);
    localparam int SYNC_HI = (ROWS + 2) / 2;
    localparam logic [RW-1:0] ROW_IND = RW'(ROWS);

    typedef struct packed {
        logic [RW-1:0] row;
        logic          fr;
        logic [NW-1:0] cnt;
        logic          sync_prev;
        logic [LW-1:0] start;
        logic [NW-1:0] nval;
        logic          nen;
        logic          rev;
    } seq_st_t;

    seq_st_t s_d, s_q;
    logic    wrap;
    logic    realign;

    assign wrap    = (s_q.row == ROW_IND);
    assign realign = ~master & sync_i & ~s_q.sync_prev;

    always_comb begin
        s_d = s_q;
        if (tick) begin
            s_d.sync_prev = sync_i;
            if (realign) begin
                s_d.row = RW'(1);
            end else if (wrap) begin
                s_d.row   = '0;
                s_d.fr    = ~s_q.fr;
                s_d.cnt   = '0;
                s_d.start = cfg_start;
                s_d.nval  = cfg_nval;
                s_d.nen   = cfg_nen;
                s_d.rev   = cfg_rev;
            end else begin
                s_d.row = s_q.row + 1'b1;
                if (s_q.nen) begin
                    if (s_q.cnt == s_q.nval) begin
                        s_d.fr  = ~s_q.fr;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign row      = s_q.row;
    assign fr       = s_q.fr;
    assign sync_gen = (s_q.row < RW'(SYNC_HI));
    assign start_sh = s_q.start;
    assign rev_sh   = s_q.rev;
endmodule

// File: rtl/lcdscan_map.sv
module lcdscan_map #(
    parameter int ROWS = 64
) (
    input  logic [$clog2(ROWS+1)-1:0] row,
    input  logic [$clog2(ROWS)-1:0]   start_sh,
    input  logic                      rev_sh,
    input  logic                      fr,
    input  logic                      pix,
    input  logic                      disp_rev,
    input  logic                      psave,
    output logic                      ind,
    output logic [$clog2(ROWS)-1:0]   ram_line,
    output logic [$clog2(ROWS)-1:0]   com_idx,
    output logic [1:0]                seg_lvl,
    output logic [1:0]                com_act,
    output logic [1:0]                com_idle
);
    import lcdscan_pkg::*;

    localparam int LW = $clog2(ROWS);
    localparam int RW = $clog2(ROWS + 1);

    logic [LW:0]   sum;
    logic [LW:0]   wrapped;
    logic [LW-1:0] low;
    logic          eff;

    assign ind = (row == RW'(ROWS));
    assign low = row[LW-1:0];

    always_comb begin
        sum     = {1'b0, start_sh} + {1'b0, low};
        wrapped = (sum >= (LW+1)'(ROWS)) ? (sum - (LW+1)'(ROWS)) : sum;
    end

    assign ram_line = ind ? '0 : wrapped[LW-1:0];
    assign com_idx  = ind ? '0 : (rev_sh ? (LW'(ROWS - 1) - low) : low);

    assign eff = pix ^ disp_rev;

    always_comb begin
        if (psave) begin
            seg_lvl  = SEG_VDD;
            com_act  = COM_VDD;
            com_idle = COM_VDD;
        end else begin
            case ({eff, fr})
                2'b11:   seg_lvl = SEG_VDD;
                2'b10:   seg_lvl = SEG_V5;
                2'b01:   seg_lvl = SEG_V2;
                default: seg_lvl = SEG_V3;
            endcase
            com_act  = fr ? COM_V5 : COM_VDD;
            com_idle = fr ? COM_V1 : COM_V4;
        end
    end
endmodule

// File: rtl/lcdscan_timing.sv
module lcdscan_timing #(
    parameter int ROWS   = 64,
    parameter int NW     = 6,
    parameter int CL_DIV = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      master_i,
    input  logic                      int_osc_i,
    input  logic                      cl_i,
    input  logic                      fr_i,
    input  logic                      sync_i,
    input  logic                      dof_i,
    input  logic [$clog2(ROWS)-1:0]   cfg_start_i,
    input  logic [NW-1:0]             cfg_nval_i,
    input  logic                      cfg_nen_i,
    input  logic                      cfg_com_rev_i,
    input  logic                      cfg_disp_rev_i,
    input  logic                      cfg_psave_i,
    input  logic                      cfg_disp_on_i,
    input  logic                      pix_i,
    output logic                      cl_o,
    output logic                      cl_oe_o,
    output logic                      fr_o,
    output logic                      fr_oe_o,
    output logic                      sync_o,
    output logic                      sync_oe_o,
    output logic                      dof_o,
    output logic                      dof_oe_o,
    output logic [$clog2(ROWS+1)-1:0] row_o,
    output logic                      ind_row_o,
    output logic [$clog2(ROWS)-1:0]   ram_line_o,
    output logic [$clog2(ROWS)-1:0]   com_idx_o,
    output logic [1:0]                seg_lvl_o,
    output logic [1:0]                com_act_lvl_o,
    output logic [1:0]                com_idle_lvl_o
);
    localparam int LW = $clog2(ROWS);
    localparam int RW = $clog2(ROWS + 1);

    logic          use_osc;
    logic          line_tick;
    logic          cl_gen;
    logic          fr_int;
    logic          sync_gen;
    logic          fr_eff;
    logic [RW-1:0] row;
    logic [LW-1:0] start_sh;
    logic          rev_sh;

    assign use_osc = master_i & int_osc_i;

    lcdscan_tick #(.CL_DIV(CL_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .use_osc (use_osc),
        .cl_i    (cl_i),
        .tick    (line_tick),
        .cl_gen  (cl_gen)
    );

    lcdscan_seq #(.ROWS(ROWS), .NW(NW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (line_tick),
        .master    (master_i),
        .sync_i    (sync_i),
        .cfg_start (cfg_start_i),
        .cfg_nval  (cfg_nval_i),
        .cfg_nen   (cfg_nen_i),
        .cfg_rev   (cfg_com_rev_i),
        .row       (row),
        .fr        (fr_int),
        .sync_gen  (sync_gen),
        .start_sh  (start_sh),
        .rev_sh    (rev_sh)
    );

    assign fr_eff = master_i ? fr_int : fr_i;

    lcdscan_map #(.ROWS(ROWS)) u_map (
        .row      (row),
        .start_sh (start_sh),
        .rev_sh   (rev_sh),
        .fr       (fr_eff),
        .pix      (pix_i),
        .disp_rev (cfg_disp_rev_i),
        .psave    (cfg_psave_i),
        .ind      (ind_row_o),
        .ram_line (ram_line_o),
        .com_idx  (com_idx_o),
        .seg_lvl  (seg_lvl_o),
        .com_act  (com_act_lvl_o),
        .com_idle (com_idle_lvl_o)
    );

    assign row_o     = row;
    assign cl_oe_o   = use_osc;
    assign cl_o      = use_osc ? cl_gen : cl_i;
    assign fr_oe_o   = master_i;
    assign fr_o      = fr_eff;
    assign sync_oe_o = master_i;
    assign sync_o    = master_i ? sync_gen : sync_i;
    assign dof_oe_o  = master_i;
    assign dof_o     = master_i ? cfg_disp_on_i : dof_i;
endmodule

// File: rtl/lcdscan_chk.sv
module lcdscan_chk #(
    parameter int ROWS = 64
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      master_i,
    input logic                      line_tick,
    input logic                      cfg_psave_i,
    input logic [$clog2(ROWS+1)-1:0] row_o,
    input logic                      ind_row_o,
    input logic [$clog2(ROWS)-1:0]   ram_line_o,
    input logic                      fr_o,
    input logic                      sync_o,
    input logic                      cl_oe_o,
    input logic                      fr_oe_o,
    input logic                      sync_oe_o,
    input logic                      dof_oe_o,
    input logic [1:0]                seg_lvl_o,
    input logic [1:0]                com_act_lvl_o,
    input logic [1:0]                com_idle_lvl_o
);
    localparam int RW      = $clog2(ROWS + 1);
    localparam int SYNC_HI = (ROWS + 2) / 2;

    p_row_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        row_o <= RW'(ROWS));

    p_row_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && line_tick && row_o != RW'(ROWS)) |=> row_o == RW'($past(row_o) + 1'b1));

    p_row_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(row_o));

    p_wrap_fr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && line_tick && row_o == RW'(ROWS)) |=>
            (row_o == '0 && (!master_i || fr_o != $past(fr_o))));

    p_fr_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && !line_tick) |=> (!master_i || $stable(fr_o)));

    p_ind_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (row_o == RW'(ROWS)) |-> (ind_row_o && ram_line_o == '0));

    p_sync_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && row_o < RW'(SYNC_HI)) |-> sync_o);

    p_slave_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !master_i |-> !(cl_oe_o || fr_oe_o || sync_oe_o || dof_oe_o));

    p_psave_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_psave_i |-> (seg_lvl_o == 2'd0 && com_act_lvl_o == 2'd0 && com_idle_lvl_o == 2'd0));
endmodule

bind lcdscan_timing lcdscan_chk #(.ROWS(ROWS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .master_i       (master_i),
    .line_tick      (line_tick),
    .cfg_psave_i    (cfg_psave_i),
    .row_o          (row_o),
    .ind_row_o      (ind_row_o),
    .ram_line_o     (ram_line_o),
    .fr_o           (fr_o),
    .sync_o         (sync_o),
    .cl_oe_o        (cl_oe_o),
    .fr_oe_o        (fr_oe_o),
    .sync_oe_o      (sync_oe_o),
    .dof_oe_o       (dof_oe_o),
    .seg_lvl_o      (seg_lvl_o),
    .com_act_lvl_o  (com_act_lvl_o),
    .com_idle_lvl_o (com_idle_lvl_o)
);

// File: tb/sim_lcdscan_timing.sv
`timescale 1ns/1ps
module sim_lcdscan_timing;
    localparam int CL_DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_i = 1'b1, int_osc_i = 1'b0, cl_i = 1'b0;
    logic       fr_i = 1'b0, sync_i = 1'b0, dof_i = 1'b0;
    logic [5:0] cfg_start_i = '0, cfg_nval_i = '0;
    logic       cfg_nen_i = 1'b0, cfg_com_rev_i = 1'b0, cfg_disp_rev_i = 1'b0;
    logic       cfg_psave_i = 1'b0, cfg_disp_on_i = 1'b1, pix_i = 1'b0;
    logic       cl_o, cl_oe_o, fr_o, fr_oe_o, sync_o, sync_oe_o, dof_o, dof_oe_o;
    logic [6:0] row_o;
    logic       ind_row_o;
    logic [5:0] ram_line_o, com_idx_o;
    logic [1:0] seg_lvl_o, com_act_lvl_o, com_idle_lvl_o;

    always #2.5 clk = ~clk;

    lcdscan_timing #(.CL_DIV(CL_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .master_i(master_i), .int_osc_i(int_osc_i),
        .cl_i(cl_i), .fr_i(fr_i), .sync_i(sync_i), .dof_i(dof_i),
        .cfg_start_i(cfg_start_i), .cfg_nval_i(cfg_nval_i), .cfg_nen_i(cfg_nen_i),
        .cfg_com_rev_i(cfg_com_rev_i), .cfg_disp_rev_i(cfg_disp_rev_i),
        .cfg_psave_i(cfg_psave_i), .cfg_disp_on_i(cfg_disp_on_i), .pix_i(pix_i),
        .cl_o(cl_o), .cl_oe_o(cl_oe_o), .fr_o(fr_o), .fr_oe_o(fr_oe_o),
        .sync_o(sync_o), .sync_oe_o(sync_oe_o), .dof_o(dof_o), .dof_oe_o(dof_oe_o),
        .row_o(row_o), .ind_row_o(ind_row_o), .ram_line_o(ram_line_o),
        .com_idx_o(com_idx_o), .seg_lvl_o(seg_lvl_o), .com_act_lvl_o(com_act_lvl_o),
        .com_idle_lvl_o(com_idle_lvl_o)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference state built from the requirements
    int m_row, m_cnt, m_start, m_nval;
    bit m_fr, m_nen, m_rev, m_prev;

    // {pix, fr, disp_rev, seg[1:0], act[1:0], idle[1:0]}  (R11, R12)
    localparam logic [8:0] LVL_TAB [8] = '{
        9'b0_0_0_10_00_10,
        9'b0_1_0_01_11_01,
        9'b1_0_0_11_00_10,
        9'b1_1_0_00_11_01,
        9'b0_0_1_11_00_10,
        9'b0_1_1_00_11_01,
        9'b1_0_1_10_00_10,
        9'b1_1_1_01_11_01
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_row = 0; m_cnt = 0; m_start = 0; m_nval = 0;
        m_fr = 0; m_nen = 0; m_rev = 0; m_prev = 0;
    endtask

    task automatic model_tick();
        if (!master_i && sync_i && !m_prev) begin
            m_row = 1;
        end else if (m_row == 64) begin
            m_row = 0; m_fr = !m_fr; m_cnt = 0;
            m_start = int'(cfg_start_i); m_nval = int'(cfg_nval_i);
            m_nen = cfg_nen_i; m_rev = cfg_com_rev_i;
        end else begin
            m_row++;
            if (m_nen) begin
                if (m_cnt == m_nval) begin m_fr = !m_fr; m_cnt = 0; end
                else m_cnt++;
            end
        end
        m_prev = sync_i;
    endtask

    task automatic check_all(input string note);
        int exp_ram, exp_com;
        exp_ram = (m_row == 64) ? 0 : (m_start + m_row) % 64;
        exp_com = (m_row == 64) ? 0 : (m_rev ? 63 - m_row : m_row);
        chk({"R1 row ", note}, int'(row_o), m_row);
        chk({"R1 ind ", note}, int'(ind_row_o), (m_row == 64) ? 1 : 0);
        chk({"R2 ram_line ", note}, int'(ram_line_o), exp_ram);
        chk({"R3 com_idx ", note}, int'(com_idx_o), exp_com);
        if (master_i) begin
            chk(m_nen ? {"R6 fr ", note} : {"R5 fr ", note}, int'(fr_o), int'(m_fr));
            chk({"R7 sync ", note}, int'(sync_o), (m_row < 33) ? 1 : 0);
        end
    endtask

    task automatic line_pulse();
        @(negedge clk) cl_i = 1'b1;
        @(negedge clk) cl_i = 1'b0;
        model_tick();
    endtask

    task automatic run_lines(input int n, input string note);
        for (int i = 0; i < n; i++) begin
            line_pulse();
            check_all(note);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int last_row, t_change, t_now, gap;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R1 reset row", int'(row_o), 0);
        chk("R5 reset fr", int'(fr_o), 0);
        chk("R7 reset sync", int'(sync_o), 1);
        chk("R8 master fr_oe", int'(fr_oe_o), 1);
        chk("R8 master sync_oe", int'(sync_oe_o), 1);
        chk("R8 master dof_oe", int'(dof_oe_o), 1);
        chk("R8 external cl_oe", int'(cl_oe_o), 0);
        chk("R8 master dof_o", int'(dof_o), 1);
        check_all("reset");

        // default frame, per-frame polarity
        run_lines(65, "default frame");
        chk("R5 fr after frame", int'(fr_o), 1);

        // new config mid-frame: must wait for the wrap (R4)
        run_lines(10, "pre-config");
        cfg_start_i = 6'd5; cfg_com_rev_i = 1'b1; cfg_nen_i = 1'b1; cfg_nval_i = 6'd3;
        run_lines(20, "R4 pending");
        run_lines(90, "R6 n=4 scroll 5 reversed");

        // toggle every line, scroll near the top end
        cfg_nval_i = 6'd0; cfg_start_i = 6'd63; cfg_com_rev_i = 1'b0;
        run_lines(80, "R6 n=1 scroll 63");

        // back to per-frame mode
        cfg_nen_i = 1'b0; cfg_start_i = 6'd32;
        run_lines(75, "R5 frame mode scroll 32");

        // power save
        @(negedge clk) cfg_psave_i = 1'b1; pix_i = 1'b1;
        #1;
        chk("R13 seg psave", int'(seg_lvl_o), 0);
        chk("R13 com act psave", int'(com_act_lvl_o), 0);
        chk("R13 com idle psave", int'(com_idle_lvl_o), 0);
        @(negedge clk) cfg_psave_i = 1'b0; pix_i = 1'b0;

        // internal divider as line clock source (R9)
        @(negedge clk) int_osc_i = 1'b1;
        #1;
        chk("R8 osc cl_oe", int'(cl_oe_o), 1);
        last_row = int'(row_o);
        t_change = -1;
        gap = 0;
        t_now = 0;
        for (int k = 0; k < 6 * CL_DIV; k++) begin
            @(negedge clk);
            t_now++;
            if (int'(row_o) != last_row) begin
                model_tick();
                check_all("R9 osc");
                chk("R9 cl high at line start", int'(cl_o), 1);
                if (t_change >= 0) gap = t_now - t_change;
                t_change = t_now;
                last_row = int'(row_o);
            end
            if (t_change >= 0 && t_now - t_change == CL_DIV / 2) begin
                chk("R9 cl low second half", int'(cl_o), 0);
            end
        end
        chk("R9 tick spacing", gap, CL_DIV);
        @(negedge clk) int_osc_i = 1'b0;

        // slave mode
        @(negedge clk) master_i = 1'b0; fr_i = 1'b1; sync_i = 1'b0; dof_i = 1'b0;
        #1;
        chk("R8 slave cl_oe", int'(cl_oe_o), 0);
        chk("R8 slave fr_oe", int'(fr_oe_o), 0);
        chk("R8 slave sync_oe", int'(sync_oe_o), 0);
        chk("R8 slave dof_oe", int'(dof_oe_o), 0);
        chk("R10 fr follows", int'(fr_o), 1);
        chk("R10 dof follows", int'(dof_o), 0);
        chk("R10 sync follows", int'(sync_o), 0);
        run_lines(3, "R10 slave free run");
        sync_i = 1'b1;
        #1;
        chk("R10 sync follows high", int'(sync_o), 1);
        line_pulse();
        chk("R10 realign row", int'(row_o), 1);
        check_all("R10 realigned");
        run_lines(2, "R10 after realign");

        // level code table in slave mode (fr from fr_i)
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            pix_i = LVL_TAB[v][8];
            fr_i = LVL_TAB[v][7];
            cfg_disp_rev_i = LVL_TAB[v][6];
            #1;
            chk($sformatf("R11 seg vec %0d", v), int'(seg_lvl_o), int'(LVL_TAB[v][5:4]));
            chk($sformatf("R12 com act vec %0d", v), int'(com_act_lvl_o), int'(LVL_TAB[v][3:2]));
            chk($sformatf("R12 com idle vec %0d", v), int'(com_idle_lvl_o), int'(LVL_TAB[v][1:0]));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule